// File: doc/BRIEF.md
# Dual-Rate Bit-Timing Recovery Loop

This block rebuilds a receive bit clock and retimed receive data from a serial bit stream that an upstream demodulator has already turned into logic levels. A local bit-phase counter divides each bit period into sixteen steps of 22.5 degrees. A prescaled tick from the system clock advances the counter, and at the default prescale of 192 a 3.6864 MHz clock gives a 1200 bit/s bit rate. Step 0 is where the counter expects a bit boundary. Every level change on the input is compared with the counter's position, and the counter is pulled toward alignment.

The size of each pull depends on the phase error. At an error of one step or less, the pull is always one step. Above that, the `fast_en` input allows a larger pull. The `quick_lock` input picks how large that pull is: four steps when it is 1, for a short lock-in, and two steps when it is 0, for a calmer and longer lock-in. The recovered clock `rt` is high while the counter is in its second half. The data is sampled where `rt` rises (mid-bit) and appears on `rd` where `rt` next falls.

Top module: `bit_timing_dpll`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `rt` and `rd` are 0 and the bit-phase counter is at step 0.
- R2: With no input transitions the counter moves one step per tick and nothing else. So `rt` repeats every 16 ticks and stays high for 8 of them.
- R3: With `fast_en` = 0, every input transition moves the counter exactly one step toward alignment, whatever the phase error.
- R4: With `fast_en` = 1 and `quick_lock` = 1, a transition whose error exceeds one step (22.5 degrees) corrects by 4 steps, or by the whole error if that is smaller.
- R5: With `fast_en` = 1 and `quick_lock` = 0, a transition whose error exceeds one step corrects by 2 steps.
- R6: A transition with an error of exactly one step corrects by one step in every mode.
- R7: A transition seen while the counter is at steps 1 to 7 retards it (the next `rt` period gets longer). At steps 8 to 15 it advances the counter (the period gets shorter). Step 8 counts as behind.
- R8: With `fast_en` = 1 and `quick_lock` = 1, alternating data that starts 180 degrees out of phase is locked within 18 bits. After that, each `rt` rise falls 6 to 9 ticks after the bit boundary.
- R9: With `fast_en` = 1 and `quick_lock` = 0, the same stimulus is locked within 50 bits, to the same window.
- R10: `rd` changes only in the cycle in which `rt` falls. It then carries the input level captured when `rt` last rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Detected serial receive bit stream |
| fast_en | input | 1 | 1 permits large corrections when the error exceeds one step |
| quick_lock | input | 1 | 1 selects the 4-step fast correction, 0 the 2-step one |
| rt | output | 1 | Recovered bit clock, high in counter steps 8 to 15 |
| rd | output | 1 | Retimed data, updated as `rt` falls |

## Verification
A wrong correction size or direction shows up as a change in the length of the single `rt` period that contains the transition. The bench can see this within one bit, because every tick adds or removes exactly one tick-width from that period. A wrong threshold or mode gate shows up the same way, on the transitions placed at one and two steps of error. A sampling or retiming fault puts wrong or shifted values on `rd` by the first falling `rt` after the faulty capture. A counter that drifts or fails to lock moves the `rt` rising edges out of the mid-bit window within a few bits.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
  typedef enum logic [1:0] {
    CORR_NONE = 2'd0,
    CORR_SLOW = 2'd1,
    CORR_FAST = 2'd2
  } corr_e;
endpackage

// File: rtl/dpll_tick_gen.sv
module dpll_tick_gen #(
  parameter int TICK_DIV = 192
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == CW'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dpll_edge_sync.sv
module dpll_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic bit_s,
  output logic edge_seen
);
  logic [SYNC_STAGES-1:0] sh_q;
  logic                   prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[SYNC_STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sh_q[SYNC_STAGES-1];
  end

  assign bit_s     = sh_q[SYNC_STAGES-1];
  assign edge_seen = bit_s ^ prev_q;
endmodule

// File: rtl/dpll_phase_ctrl.sv
module dpll_phase_ctrl
  import dpll_pkg::*;
#(
  parameter int PH_W     = 4,
  parameter int SLOW_THR = 1,
  parameter int FAST_Q   = 4,
  parameter int FAST_S   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            edge_in,
  input  logic            fast_en,
  input  logic            quick_lock,
  output logic [PH_W-1:0] phase,
  output logic            use_edge
);
  localparam int FULL = 1 << PH_W;
  localparam int HALF = FULL / 2;
  localparam int MW   = PH_W + 1;

  logic            pend_q;
  logic            ahead;
  logic [MW-1:0]   mag;
  logic [MW-1:0]   lim;
  logic [MW-1:0]   step;
  corr_e           mode;
  logic [PH_W-1:0] nxt;

  always_comb begin
    use_edge = pend_q | edge_in;
    ahead    = (phase != '0) && (phase < PH_W'(HALF));
    if (phase == '0)  mag = '0;
    else if (ahead)   mag = {1'b0, phase};
    else              mag = MW'(FULL) - {1'b0, phase};
    lim = quick_lock ? MW'(FAST_Q) : MW'(FAST_S);
    if (mag == '0)                           mode = CORR_NONE;
    else if (fast_en && (mag > MW'(SLOW_THR))) mode = CORR_FAST;
    else                                     mode = CORR_SLOW;
    case (mode)
      CORR_SLOW: step = MW'(1);
      CORR_FAST: step = (lim < mag) ? lim : mag;
      default:   step = '0;
    endcase
    if (ahead) nxt = phase + PH_W'(1) - step[PH_W-1:0];
    else       nxt = phase + PH_W'(1) + step[PH_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= '0;
      pend_q <= 1'b0;
    end else if (tick) begin
      pend_q <= 1'b0;
      phase  <= use_edge ? nxt : phase + PH_W'(1);
    end else if (edge_in) begin
      pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dpll_retimer.sv
module dpll_retimer (
  input  logic clk,
  input  logic rst,
  input  logic upper_half,
  input  logic bit_s,
  output logic rt,
  output logic rd
);
  logic hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rt     <= 1'b0;
      rd     <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      rt <= upper_half;
      if (upper_half && !rt) hold_q <= bit_s;
      if (!upper_half && rt) rd     <= hold_q;
    end
  end
endmodule

// File: rtl/bit_timing_dpll.sv
module bit_timing_dpll #(
  parameter int TICK_DIV    = 192,
  parameter int PH_W        = 4,
  parameter int SLOW_THR    = 1,
  parameter int FAST_Q      = 4,
  parameter int FAST_S      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_bit,
  input  logic fast_en,
  input  logic quick_lock,
  output logic rt,
  output logic rd
);
  logic            tick;
  logic            bit_s;
  logic            edge_in;
  logic            use_edge;
  logic [PH_W-1:0] phase;

  dpll_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  dpll_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rx_bit), .bit_s(bit_s), .edge_seen(edge_in)
  );

  dpll_phase_ctrl #(
    .PH_W(PH_W), .SLOW_THR(SLOW_THR), .FAST_Q(FAST_Q), .FAST_S(FAST_S)
  ) u_phase (
    .clk(clk), .rst(rst), .tick(tick), .edge_in(edge_in),
    .fast_en(fast_en), .quick_lock(quick_lock),
    .phase(phase), .use_edge(use_edge)
  );

  dpll_retimer u_retime (
    .clk(clk), .rst(rst), .upper_half(phase[PH_W-1]), .bit_s(bit_s),
    .rt(rt), .rd(rd)
  );
endmodule

// File: rtl/dpll_chk.sv
module dpll_chk #(
  parameter int PH_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            tick,
  input logic            use_edge,
  input logic            fast_en,
  input logic [PH_W-1:0] phase,
  input logic            rt,
  input logic            rd
);
  logic [PH_W-1:0] ph_prev;
  logic [PH_W-1:0] diff;

  always_ff @(posedge clk) begin
    if (rst) ph_prev <= '0;
    else     ph_prev <= phase;
  end
  assign diff = phase - ph_prev;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!rt && !rd && phase == '0));

  // R2
  free_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !use_edge) |=> (diff == PH_W'(1)));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> (diff == '0));

  // R3
  slow_only_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && use_edge && !fast_en) |=> (diff <= PH_W'(2)));

  // R10
  rd_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd) |-> $fell(rt));
endmodule

bind bit_timing_dpll dpll_chk #(.PH_W(PH_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .use_edge(use_edge),
  .fast_en(fast_en), .phase(phase), .rt(rt), .rd(rd)
);

// File: tb/bit_timing_dpll_tb.sv
module bit_timing_dpll_tb;
  localparam int DIV     = 16;
  localparam int CLK_NS  = 10;
  localparam int BIT_CLK = 16 * DIV;
  localparam logic [15:0] PAT = 16'b1101_0011_1000_1011;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_bit = 1'b0;
  logic fast_en = 1'b1;
  logic quick_lock = 1'b1;
  logic rt, rd;

  always #5 clk = ~clk;

  bit_timing_dpll #(.TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .fast_en(fast_en),
    .quick_lock(quick_lock), .rt(rt), .rd(rd)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  bit    mon_en = 1'b0;
  bit    win_en = 1'b0;
  string win_req = "";
  time   bound_t = 0;
  logic  exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // scoreboard: sampler pushes the driven level at each rt rise
  always @(posedge rt) if (mon_en) exp_q.push_back(rx_bit);

  // monitor: pops at each rt fall and compares with rd (R10)
  always @(negedge rt) begin
    logic e;
    if (mon_en && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      @(negedge clk);
      chk(rd === e, "R10", "rd after rt fall", longint'(rd), longint'(e));
    end
  end

  // lock window: rt must rise near mid-bit (R8/R9)
  always @(posedge rt) begin
    longint d;
    if (win_en) begin
      d = longint'((($time - bound_t)) / CLK_NS);
      chk(d >= 6 * DIV && d <= 9 * DIV, win_req,
          "rt rise offset from bit start (clocks)", d, 15 * DIV / 2);
    end
  end

  // one transition at counter step p, then measure the rt period
  task automatic measure(input int p, input int delta, input string req);
    time    t0, t1;
    longint got;
    int     k;
    @(posedge rt);
    t0 = $time;
    k = (p + 8) % 16;
    repeat (k * DIV + DIV / 2) @(posedge clk);
    @(negedge clk);
    rx_bit = ~rx_bit;
    @(posedge rt);
    t1 = $time;
    got = longint'((t1 - t0) / CLK_NS);
    chk(got == (16 + delta) * DIV, req, "rt period (clocks)",
        got, longint'((16 + delta) * DIV));
  endtask

  task automatic lock_run(input int lock_bits, input string req,
                          input bit with_pat);
    @(posedge rt);
    repeat (DIV / 2) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < lock_bits + 8; i++) begin
      rx_bit  = ~rx_bit;
      bound_t = $time;
      if (i == lock_bits) begin
        win_req = req;
        win_en  = 1'b1;
      end
      repeat (BIT_CLK) @(negedge clk);
    end
    if (with_pat) begin
      mon_en = 1'b1;
      for (int i = 0; i < 16; i++) begin
        rx_bit  = PAT[15 - i];
        bound_t = $time;
        repeat (BIT_CLK) @(negedge clk);
      end
    end
    win_en = 1'b0;
    mon_en = 1'b0;
    repeat (BIT_CLK) @(negedge clk);
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    time t0, t1, t2;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(rt === 1'b0, "R1", "rt in reset", longint'(rt), 0);
    chk(rd === 1'b0, "R1", "rd in reset", longint'(rd), 0);
    rst = 1'b0;

    // R2 free running
    @(posedge rt); t0 = $time;
    @(negedge rt); t1 = $time;
    @(posedge rt); t2 = $time;
    chk((t1 - t0) / CLK_NS == 8 * DIV, "R2", "rt high time",
        longint'((t1 - t0) / CLK_NS), 8 * DIV);
    chk((t2 - t0) / CLK_NS == 16 * DIV, "R2", "rt period",
        longint'((t2 - t0) / CLK_NS), 16 * DIV);

    // large-step mode, 4-step limit
    fast_en = 1'b1; quick_lock = 1'b1;
    measure(6, 4, "R4");
    measure(2, 2, "R4");
    measure(12, -4, "R7");
    measure(1, 1, "R6");
    measure(15, -1, "R6");
    // 2-step limit
    quick_lock = 1'b0;
    measure(6, 2, "R5");
    measure(12, -2, "R5");
    // slow only
    fast_en = 1'b0;
    measure(6, 1, "R3");
    measure(12, -1, "R3");
    measure(8, -1, "R7");

    // lock-in and retimed data
    fast_en = 1'b1; quick_lock = 1'b1;
    lock_run(18, "R8", 1'b1);
    quick_lock = 1'b0;
    lock_run(50, "R9", 1'b0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule